// File: doc/BRIEF.md
# Per-Bit Deskew Normalizer and Step Estimator

This block sits behind a per-bit skew sweep of a memory PHY data path. The sweep delivers one tagged result word for each data bit of each byte lane. The block keeps, for every lane, the smallest and largest fine-delay value seen, and it also keeps the value of every bit. When the sweep reports that it has finished, the block emits register write requests for each lane in ascending lane order. It first clears the lane's deskew register slots. It then writes each bit's delay, measured from the lane minimum, to the slot named by a physical pad map.

For each lane the block also derives a strobe offset equal to half of the lane's fine spread. In transmit mode this offset is written to two strobe slots. In receive mode it is kept per lane and per chip select for later use. The block also estimates the delay of one fine step in picoseconds. The estimate comes from the ratio of the coarse-delay spread, in picoseconds, to the fine spread, with a fixed fallback of 12. A single sequential restoring divider is shared by the coarse-tap calculation and every lane's estimate. `done` rises once the last lane is finished.

Top module: `deskew_norm`

## Requirements
- R1: A `start` pulse accepted in the idle or done state clears every lane's stored bit values to 0, its minimum to 31 and its maximum to 0, clears `if_fail`, and opens result collection.
- R2: During collection, a result word with bit 25 set stores bits [4:0] for the tagged lane and bit and merges them into that lane's minimum and maximum. A first-pass word (`res_second`=0) with bit 25 clear changes nothing.
- R3: A second-pass word (`res_second`=1) with bit 25 clear stores 31 for that bit and forces the lane maximum to 31.
- R4: After `finish`, lanes are processed in ascending order. Each lane first gets 12 writes of 0 to addresses base + 16·cs + 0..11, where base is 0x50 when `mode_tx`=0 and 0x10 when `mode_tx`=1, and cs is `cs_sel` sampled at `finish`. The first write appears 23 cycles after the cycle in which `finish` is driven.
- R5: Next, bits 0..7 are written in order to address base + 16·cs + pad. Pad is the 4-bit field `pad_map[(lane·8+bit)·4 +: 4]`. The data is the stored value minus the lane minimum.
- R6: A lane whose `lane_lock` bit is 0 at `finish` has all per-bit data written as 0. Its minimum and maximum count as 0, so its estimate is 12. `if_fail` is set while any lane is unlocked.
- R7: The coarse tap in picoseconds is floor(15625 / `freq_mhz`), which is the same as 1,000,000 / f / 64. `freq_mhz` must be nonzero.
- R8: Each lane reports once on `step_vld` with `step_lane`. The estimate is 12 when the lane maximum equals the lane minimum. Otherwise it is floor((coarse max − coarse min) · tap / (max − min)).
- R9: The strobe offset is (max − min) / 2. With `mode_tx`=1 it is written after the bit writes to base + 16·cs + 4 and then + 5. With `mode_tx`=0 it is stored for that lane and chip select, and it appears on `rx_strobe[lane·5 +: 5]` for the chip select currently on `cs_sel`. Transmit runs leave the stored values unchanged.
- R10: `done` is 0 from reset until every lane has been processed. It then stays 1, with no write requests, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new collection |
| finish | input | 1 | Sweep finished; begin write-back |
| mode_tx | input | 1 | 1 = transmit, 0 = receive |
| cs_sel | input | 2 | Chip select |
| freq_mhz | input | 12 | Clock frequency in MHz |
| lane_lock | input | 2 | Per-lane lock flags |
| crs_min | input | 12 | Per-lane coarse minimum, 6 bits each |
| crs_max | input | 12 | Per-lane coarse maximum, 6 bits each |
| pad_map | input | 64 | Physical pad per lane and bit, 4 bits each |
| res_valid | input | 1 | Result word present |
| res_second | input | 1 | Result belongs to the opposite-edge pass |
| res_lane | input | 1 | Lane tag |
| res_bit | input | 3 | Bit tag |
| res_word | input | 32 | Result word |
| wr_en | output | 1 | Register write request |
| wr_addr | output | 8 | Write address |
| wr_data | output | 5 | Write data |
| step_vld | output | 1 | Step estimate valid |
| step_lane | output | 1 | Lane of the estimate |
| step_ps | output | 20 | Step estimate in picoseconds |
| rx_strobe | output | 10 | Stored receive strobe offsets for `cs_sel` |
| if_fail | output | 1 | Some lane unlocked |
| done | output | 1 | All lanes finished |

## Verification
Each write is registered. The first write of a run lands 23 cycles after the cycle in which `finish` is driven: one cycle to load the divider, twenty iterations for the coarse tap, one cycle for the state change and one for the output register. Within a lane the writes then follow back to back. The bench counts clock edges and checks the first-write latency exactly. It captures every write and every estimate on the falling edge, so that it samples half a cycle after the registers change. It then compares the captured order, addresses and data with a list it builds from the results it sent. `done`, `if_fail` and `rx_strobe` are sampled only after `done` has been seen high.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_COLLECT, ST_TAPW, ST_CLR, ST_BITW,
    ST_STB, ST_EST, ST_ESTW, ST_NEXT, ST_DONE
  } dsk_state_e;
  localparam int RES_OK_BIT   = 25;
  localparam int FALLBACK_PS  = 12;
  localparam int TAP_NUM      = 15625;
endpackage

// File: rtl/dsk_lane_stats.sv
module dsk_lane_stats #(
  parameter int BITS  = 8,
  parameter int VW    = 5,
  parameter int BIT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             upd,
  input  logic             second,
  input  logic             wok,
  input  logic [BIT_W-1:0] wbit,
  input  logic [VW-1:0]    wval,
  input  logic [BIT_W-1:0] rd_bit,
  output logic [VW-1:0]    rd_val,
  output logic [VW-1:0]    min_o,
  output logic [VW-1:0]    max_o
);
  localparam logic [VW-1:0] TOP = '1;

  logic [VW-1:0] val_q [BITS];
  logic [VW-1:0] val_d [BITS];
  logic [VW-1:0] min_q, min_d, max_q, max_d;
  logic          en;

  assign en = init | upd;

  always_comb begin
    val_d = val_q;
    min_d = min_q;
    max_d = max_q;
    if (init) begin
      for (int i = 0; i < BITS; i++) val_d[i] = '0;
      min_d = TOP;
      max_d = '0;
    end else if (upd) begin
      if (wok) begin
        val_d[wbit] = wval;
        if (wval < min_q) min_d = wval;
        if (wval > max_q) max_d = wval;
      end else if (second) begin
        val_d[wbit] = TOP;
        max_d       = TOP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BITS; i++) val_q[i] <= '0;
      min_q <= TOP;
      max_q <= '0;
    end else if (en) begin
      val_q <= val_d;
      min_q <= min_d;
      max_q <= max_d;
    end
  end

  assign rd_val = val_q[rd_bit];
  assign min_o  = min_q;
  assign max_o  = max_q;

  AST_INIT_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (min_o == TOP && max_o == '0)); // R1
  AST_FIRST_FAIL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !init && !wok && !second) |=> ($stable(min_o) && $stable(max_o))); // R2
  AST_SECOND_FAIL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !init && !wok && second) |=> (max_o == TOP)); // R3
endmodule

// File: rtl/dsk_divider.sv
module dsk_divider #(
  parameter int NW = 20,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          fin,
  output logic [NW-1:0] quo
);
  localparam int CNT_W = $clog2(NW + 1);

  logic [DW:0]    rem_q, rem_d, trial, diff;
  logic [NW-1:0]  quo_q, quo_d;
  logic [DW-1:0]  den_q, den_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic           busy_q, busy_d, fin_q, fin_d;

  assign trial = {rem_q[DW-1:0], quo_q[NW-1]};
  assign diff  = trial - {1'b0, den_q};

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    fin_d  = 1'b0;
    if (go) begin
      rem_d  = '0;
      quo_d  = num;
      den_d  = den;
      cnt_d  = CNT_W'(NW);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (trial >= {1'b0, den_q}) begin
        rem_d = diff;
        quo_d = {quo_q[NW-2:0], 1'b1};
      end else begin
        rem_d = trial;
        quo_d = {quo_q[NW-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      fin_q  <= fin_d;
    end
  end

  assign busy = busy_q;
  assign fin  = fin_q;
  assign quo  = quo_q;

  AST_GO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy); // R7
  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (rem_q < {1'b0, den_q})); // R8
endmodule

// File: rtl/deskew_norm.sv
module deskew_norm
  import deskew_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int BITS      = 8,
  parameter int VW        = 5,
  parameter int CW        = 6,
  parameter int FREQ_W    = 12,
  parameter int CS_NUM    = 4,
  parameter int ADDR_W    = 8,
  parameter int NW        = 20,
  parameter int RX_BASE   = 'h50,
  parameter int TX_BASE   = 'h10,
  parameter int STB_OFF   = 4,
  parameter int CS_STRIDE = 16,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int BIT_W  = $clog2(BITS),
  localparam int SLOTS  = BITS + 4,
  localparam int PW     = $clog2(SLOTS),
  localparam int CS_W   = $clog2(CS_NUM)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     finish,
  input  logic                     mode_tx,
  input  logic [CS_W-1:0]          cs_sel,
  input  logic [FREQ_W-1:0]        freq_mhz,
  input  logic [LANES-1:0]         lane_lock,
  input  logic [LANES*CW-1:0]      crs_min,
  input  logic [LANES*CW-1:0]      crs_max,
  input  logic [LANES*BITS*PW-1:0] pad_map,
  input  logic                     res_valid,
  input  logic                     res_second,
  input  logic [LANE_W-1:0]        res_lane,
  input  logic [BIT_W-1:0]         res_bit,
  input  logic [31:0]              res_word,
  output logic                     wr_en,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic [VW-1:0]            wr_data,
  output logic                     step_vld,
  output logic [LANE_W-1:0]        step_lane,
  output logic [NW-1:0]            step_ps,
  output logic [LANES*VW-1:0]      rx_strobe,
  output logic                     if_fail,
  output logic                     done
);
  localparam int DEN_W = (FREQ_W > VW) ? FREQ_W : VW;
  localparam logic [PW-1:0] LAST_SLOT = PW'(SLOTS - 1);
  localparam logic [PW-1:0] LAST_BIT  = PW'(BITS - 1);

  dsk_state_e state_q, state_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [PW-1:0]     idx_q, idx_d;
  logic              mode_q, mode_d;
  logic [CS_W-1:0]   cs_q, cs_d;
  logic [LANES-1:0]  lock_q, lock_d;
  logic [NW-1:0]     tap_q, tap_d;
  logic              fail_q, fail_d;
  logic              wr_en_q, wr_en_d;
  logic [ADDR_W-1:0] wr_addr_q, wr_addr_d;
  logic [VW-1:0]     wr_data_q, wr_data_d;
  logic              step_vld_q, step_vld_d;
  logic [LANE_W-1:0] step_lane_q, step_lane_d;
  logic [NW-1:0]     step_ps_q, step_ps_d;
  logic [VW-1:0]     rx_stb_q [LANES*CS_NUM];
  logic [VW-1:0]     rx_stb_d [LANES*CS_NUM];

  // Per-lane statistics
  logic [VW-1:0] min_a [LANES];
  logic [VW-1:0] max_a [LANES];
  logic [VW-1:0] rdv_a [LANES];
  logic          init_stats;

  assign init_stats = start && (state_q == ST_IDLE || state_q == ST_DONE);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic upd_l;
    assign upd_l = res_valid && (state_q == ST_COLLECT) && (res_lane == LANE_W'(l));
    dsk_lane_stats #(.BITS(BITS), .VW(VW), .BIT_W(BIT_W)) u_stats (
      .clk    (clk),
      .rst_n  (rst_n),
      .init   (init_stats),
      .upd    (upd_l),
      .second (res_second),
      .wok    (res_word[RES_OK_BIT]),
      .wbit   (res_bit),
      .wval   (res_word[VW-1:0]),
      .rd_bit (idx_q[BIT_W-1:0]),
      .rd_val (rdv_a[l]),
      .min_o  (min_a[l]),
      .max_o  (max_a[l])
    );
    assign rx_strobe[l*VW +: VW] = rx_stb_q[l*CS_NUM + int'(cs_sel)];
  end

  logic unused_word;
  assign unused_word = ^{res_word[31:RES_OK_BIT+1], res_word[RES_OK_BIT-1:VW]};

  // Current-lane datapath
  logic              lock_cur;
  logic [VW-1:0]     eff_min, eff_max, spread, half;
  logic [PW-1:0]     pad_cur;
  logic [CW-1:0]     crs_span;
  logic [ADDR_W-1:0] row_base;
  logic [CW+NW-1:0]  prod;
  logic              unused_prod;

  assign lock_cur = lock_q[lane_q];
  assign eff_min  = lock_cur ? min_a[lane_q] : '0;
  assign eff_max  = lock_cur ? max_a[lane_q] : '0;
  assign spread   = eff_max - eff_min;
  assign half     = spread >> 1;
  assign pad_cur  = pad_map[(int'(lane_q)*BITS + int'(idx_q[BIT_W-1:0]))*PW +: PW];
  assign crs_span = crs_max[int'(lane_q)*CW +: CW] - crs_min[int'(lane_q)*CW +: CW];
  assign row_base = ADDR_W'(mode_q ? TX_BASE : RX_BASE) + ADDR_W'(CS_STRIDE * int'(cs_q));
  assign prod     = {{NW{1'b0}}, crs_span} * {{CW{1'b0}}, tap_q};
  assign unused_prod = ^prod[CW+NW-1:NW];

  // Shared divider
  logic             div_go, div_fin, div_busy_unused;
  logic [NW-1:0]    div_num, div_quo;
  logic [DEN_W-1:0] div_den;

  dsk_divider #(.NW(NW), .DW(DEN_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .num   (div_num),
    .den   (div_den),
    .busy  (div_busy_unused),
    .fin   (div_fin),
    .quo   (div_quo)
  );

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    lane_d      = lane_q;
    idx_d       = idx_q;
    mode_d      = mode_q;
    cs_d        = cs_q;
    lock_d      = lock_q;
    tap_d       = tap_q;
    fail_d      = fail_q;
    wr_en_d     = 1'b0;
    wr_addr_d   = wr_addr_q;
    wr_data_d   = wr_data_q;
    step_vld_d  = 1'b0;
    step_lane_d = step_lane_q;
    step_ps_d   = step_ps_q;
    rx_stb_d    = rx_stb_q;
    div_go      = 1'b0;
    div_num     = NW'(TAP_NUM);
    div_den     = DEN_W'(freq_mhz);
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d = ST_COLLECT;
          fail_d  = 1'b0;
        end
      end
      ST_COLLECT: begin
        if (finish) begin
          mode_d  = mode_tx;
          cs_d    = cs_sel;
          lock_d  = lane_lock;
          fail_d  = ~&lane_lock;
          div_go  = 1'b1;
          state_d = ST_TAPW;
        end
      end
      ST_TAPW: begin
        if (div_fin) begin
          tap_d   = div_quo;
          lane_d  = '0;
          idx_d   = '0;
          state_d = ST_CLR;
        end
      end
      ST_CLR: begin
        wr_en_d   = 1'b1;
        wr_addr_d = row_base + ADDR_W'(idx_q);
        wr_data_d = '0;
        if (idx_q == LAST_SLOT) begin
          idx_d   = '0;
          state_d = ST_BITW;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_BITW: begin
        wr_en_d   = 1'b1;
        wr_addr_d = row_base + ADDR_W'(pad_cur);
        wr_data_d = lock_cur ? (rdv_a[lane_q] - eff_min) : '0;
        if (idx_q == LAST_BIT) begin
          idx_d   = '0;
          state_d = ST_STB;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_STB: begin
        if (mode_q) begin
          wr_en_d   = 1'b1;
          wr_addr_d = row_base + ADDR_W'(STB_OFF) + ADDR_W'(idx_q);
          wr_data_d = half;
          if (idx_q == PW'(1)) begin
            idx_d   = '0;
            state_d = ST_EST;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else begin
          rx_stb_d[int'(lane_q)*CS_NUM + int'(cs_q)] = half;
          state_d = ST_EST;
        end
      end
      ST_EST: begin
        if (spread == '0) begin
          step_vld_d  = 1'b1;
          step_lane_d = lane_q;
          step_ps_d   = NW'(FALLBACK_PS);
          state_d     = ST_NEXT;
        end else begin
          div_go  = 1'b1;
          div_num = prod[NW-1:0];
          div_den = DEN_W'(spread);
          state_d = ST_ESTW;
        end
      end
      ST_ESTW: begin
        if (div_fin) begin
          step_vld_d  = 1'b1;
          step_lane_d = lane_q;
          step_ps_d   = div_quo;
          state_d     = ST_NEXT;
        end
      end
      ST_NEXT: begin
        idx_d = '0;
        if (lane_q == LANE_W'(LANES - 1)) begin
          state_d = ST_DONE;
        end else begin
          lane_d  = lane_q + 1'b1;
          state_d = ST_CLR;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      lane_q      <= '0;
      idx_q       <= '0;
      mode_q      <= 1'b0;
      cs_q        <= '0;
      lock_q      <= '0;
      tap_q       <= '0;
      fail_q      <= 1'b0;
      wr_en_q     <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
      step_vld_q  <= 1'b0;
      step_lane_q <= '0;
      step_ps_q   <= '0;
      for (int i = 0; i < LANES*CS_NUM; i++) rx_stb_q[i] <= '0;
    end else begin
      state_q     <= state_d;
      lane_q      <= lane_d;
      idx_q       <= idx_d;
      mode_q      <= mode_d;
      cs_q        <= cs_d;
      lock_q      <= lock_d;
      tap_q       <= tap_d;
      fail_q      <= fail_d;
      wr_en_q     <= wr_en_d;
      wr_addr_q   <= wr_addr_d;
      wr_data_q   <= wr_data_d;
      step_vld_q  <= step_vld_d;
      step_lane_q <= step_lane_d;
      step_ps_q   <= step_ps_d;
      rx_stb_q    <= rx_stb_d;
    end
  end

  assign wr_en     = wr_en_q;
  assign wr_addr   = wr_addr_q;
  assign wr_data   = wr_data_q;
  assign step_vld  = step_vld_q;
  assign step_lane = step_lane_q;
  assign step_ps   = step_ps_q;
  assign if_fail   = fail_q;
  assign done      = (state_q == ST_DONE);

  AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en); // R10
  AST_UNLOCKED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_vld && !lock_q[step_lane]) |-> (step_ps == NW'(FALLBACK_PS))); // R6
endmodule

// File: tb/deskew_norm_tb.sv
`timescale 1ns/1ps
module deskew_norm_tb;
  logic        clk, rst_n;
  logic        start, finish, mode_tx;
  logic [1:0]  cs_sel;
  logic [11:0] freq_mhz;
  logic [1:0]  lane_lock;
  logic [11:0] crs_min, crs_max;
  logic [63:0] pad_map;
  logic        res_valid, res_second;
  logic        res_lane;
  logic [2:0]  res_bit;
  logic [31:0] res_word;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [4:0]  wr_data;
  logic        step_vld;
  logic        step_lane;
  logic [19:0] step_ps;
  logic [9:0]  rx_strobe;
  logic        if_fail, done;

  deskew_norm u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .finish(finish), .mode_tx(mode_tx),
    .cs_sel(cs_sel), .freq_mhz(freq_mhz), .lane_lock(lane_lock),
    .crs_min(crs_min), .crs_max(crs_max), .pad_map(pad_map),
    .res_valid(res_valid), .res_second(res_second), .res_lane(res_lane),
    .res_bit(res_bit), .res_word(res_word), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .step_vld(step_vld), .step_lane(step_lane),
    .step_ps(step_ps), .rx_strobe(rx_strobe), .if_fail(if_fail), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Capture
  int ncap = 0;
  int cap_a [64];
  int cap_d [64];
  int cap_c [64];
  int step_got [2];
  int step_cnt [2];
  always @(negedge clk) begin
    if (wr_en && ncap < 64) begin
      cap_a[ncap] = int'(wr_addr);
      cap_d[ncap] = int'(wr_data);
      cap_c[ncap] = cyc;
      ncap++;
    end
    if (step_vld) begin
      step_got[step_lane] = int'(step_ps);
      step_cnt[step_lane]++;
    end
  end

  // Bench model of stored results
  int m_val [2][8];
  int m_min [2];
  int m_max [2];
  int pads  [2][8];

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
    summary_and_end();
  end

  task automatic do_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int l = 0; l < 2; l++) begin
      m_min[l] = 31;
      m_max[l] = 0;
      for (int b = 0; b < 8; b++) m_val[l][b] = 0;
    end
  endtask

  task automatic send(int lane, int bitn, bit second, bit ok, int val);
    res_valid  = 1'b1;
    res_lane   = lane[0];
    res_bit    = bitn[2:0];
    res_second = second;
    res_word   = {6'h2a, ok, 20'h0, val[4:0]};
    @(negedge clk);
    res_valid  = 1'b0;
    if (ok) begin
      m_val[lane][bitn] = val;
      if (val < m_min[lane]) m_min[lane] = val;
      if (val > m_max[lane]) m_max[lane] = val;
    end else if (second) begin
      m_val[lane][bitn] = 31;
      m_max[lane] = 31;
    end
  endtask

  // finish, wait for done, compare captured stream with expectation
  task automatic finish_and_check(bit tx, int cs, int freq, logic [1:0] lock,
                                  int cmin0, int cmax0, int cmin1, int cmax1);
    int fcyc, k, base, tap, lo, hi, sp, exp_step, cmn, cmx, waited;
    mode_tx   = tx;
    cs_sel    = cs[1:0];
    freq_mhz  = freq[11:0];
    lane_lock = lock;
    crs_min   = {cmin1[5:0], cmin0[5:0]};
    crs_max   = {cmax1[5:0], cmax0[5:0]};
    ncap = 0;
    step_cnt[0] = 0;
    step_cnt[1] = 0;
    finish = 1'b1;
    fcyc = cyc;
    @(negedge clk);
    finish = 1'b0;
    waited = 0;
    while (!done && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    check("R10 done rises", int'(done), 1);
    repeat (4) @(negedge clk);
    check("R10 done holds", int'(done), 1);
    check("R4 first write latency", (ncap > 0) ? cap_c[0] - fcyc : -1, 23);
    base = (tx ? 'h10 : 'h50) + 16 * cs;
    tap  = 15625 / freq;
    k = 0;
    check("R4 write count", ncap, tx ? 44 : 40);
    for (int l = 0; l < 2; l++) begin
      lo = lock[l] ? m_min[l] : 0;
      hi = lock[l] ? m_max[l] : 0;
      sp = hi - lo;
      for (int s = 0; s < 12; s++) begin
        check($sformatf("R4 clear addr lane%0d slot%0d", l, s), cap_a[k], base + s);
        check($sformatf("R4 clear data lane%0d slot%0d", l, s), cap_d[k], 0);
        k++;
      end
      for (int b = 0; b < 8; b++) begin
        check($sformatf("R5 bit addr lane%0d bit%0d", l, b), cap_a[k], base + pads[l][b]);
        check($sformatf("R5/R6 bit data lane%0d bit%0d", l, b), cap_d[k],
              lock[l] ? m_val[l][b] - lo : 0);
        k++;
      end
      if (tx) begin
        for (int s = 0; s < 2; s++) begin
          check($sformatf("R9 strobe addr lane%0d", l), cap_a[k], base + 4 + s);
          check($sformatf("R9 strobe data lane%0d", l), cap_d[k], sp / 2);
          k++;
        end
      end
      cmn = (l == 0) ? cmin0 : cmin1;
      cmx = (l == 0) ? cmax0 : cmax1;
      exp_step = (sp == 0) ? 12 : ((cmx - cmn) * tap) / sp;
      check($sformatf("R8 step count lane%0d", l), step_cnt[l], 1);
      check($sformatf("R7/R8 step value lane%0d", l), step_got[l], exp_step);
    end
    check("R6 if_fail", int'(if_fail), (lock == 2'b11) ? 0 : 1);
    k = ncap;
    repeat (3) @(negedge clk);
    check("R10 no writes while done", ncap, k);
  endtask

  task automatic t_reset();
    check("R10 done after reset", int'(done), 0);
    check("R10 no write after reset", int'(wr_en), 0);
    check("R6 if_fail after reset", int'(if_fail), 0);
    check("R9 rx_strobe after reset", int'(rx_strobe), 0);
  endtask

  // RX, chip select 0, both lanes locked, dropped first-pass failure, second-pass failure
  task automatic t_rx_locked();
    int v0 [8] = '{3, 5, 7, 4, 9, 6, 5, 8};
    int v1 [8] = '{10, 12, 0, 11, 15, 14, 13, 12};
    do_start();
    for (int b = 0; b < 8; b++) send(0, b, 1'b0, 1'b1, v0[b]);
    send(0, 0, 1'b0, 1'b0, 0);    // R2 dropped
    for (int b = 0; b < 8; b++) if (b != 2) send(1, b, 1'b0, 1'b1, v1[b]);
    send(1, 2, 1'b1, 1'b0, 1);    // R3 forced to 31
    check("R2 model min lane0", m_min[0], 3);
    check("R3 model max lane1", m_max[1], 31);
    finish_and_check(1'b0, 0, 800, 2'b11, 10, 30, 5, 45);
    cs_sel = 2'd0;
    #1;
    check("R9 rx strobe lane0 cs0", int'(rx_strobe[4:0]), 3);
    check("R9 rx strobe lane1 cs0", int'(rx_strobe[9:5]), 10);
  endtask

  // TX, chip select 1, lane0 flat (fallback), lane1 unlocked
  task automatic t_tx_unlocked();
    do_start();
    for (int b = 0; b < 8; b++) send(0, b, 1'b0, 1'b1, 7);
    for (int b = 0; b < 8; b++) send(1, b, 1'b0, 1'b1, 20 - b);
    check("R1 model min lane0 reset by start", m_min[0], 7);
    finish_and_check(1'b1, 1, 400, 2'b01, 2, 20, 4, 40);
    cs_sel = 2'd0;
    #1;
    check("R9 tx leaves rx strobe lane0", int'(rx_strobe[4:0]), 3);
    check("R9 tx leaves rx strobe lane1", int'(rx_strobe[9:5]), 10);
    cs_sel = 2'd1;
    #1;
    check("R9 rx strobe cs1 unwritten", int'(rx_strobe), 0);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 start clears if_fail", int'(if_fail), 0);
    check("R10 done drops on start", int'(done), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; finish = 1'b0; mode_tx = 1'b0; cs_sel = 2'd0;
    freq_mhz = 12'd800; lane_lock = 2'b11; crs_min = '0; crs_max = '0;
    res_valid = 1'b0; res_second = 1'b0; res_lane = 1'b0; res_bit = 3'd0; res_word = '0;
    step_got[0] = 0; step_got[1] = 0; step_cnt[0] = 0; step_cnt[1] = 0;
    pad_map = '0;
    for (int b = 0; b < 8; b++) begin
      pads[0][b] = b;
      pads[1][b] = 11 - b;
      pad_map[(0*8 + b)*4 +: 4] = 4'(b);
      pad_map[(1*8 + b)*4 +: 4] = 4'(11 - b);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_locked();
    t_tx_unlocked();
    summary_and_end();
  end
endmodule